// File: doc/BRIEF.md
# Network Controller Bring-Up Sequencer

This block brings an SPI-attached Ethernet controller from power-up to a known-good state before any other logic talks to it. After a system reset or a `start` pulse, it drives the controller's active-low reset pin low for a programmed number of clocks and then releases it. Next it waits for the controller's internal clock to lock. Only after that wait does it make its first register access.

All accesses are single bytes. They go out through a request/response port to a separate SPI frame master, which serialises the 16-bit offset, the control byte and the data byte. The sequencer first reads the version register and accepts only the value 0x04. It then writes the 48-bit hardware address from `mac_in` into the common register block and reads all six bytes back. It declares success only when every byte read back matches the byte written.

On success, `ready` rises and stays high until the next `start`. On failure, `err` rises with a 2-bit cause code and holds until the next `start`.

Top module: `bup_seq`

## Requirements
- R1: After `rst` or a `start` pulse, `slv_rst_n` goes low and stays low for at least `RST_TICKS` clocks (default 25000, 500 us at 50 MHz). While it is low, `req_valid` stays low.
- R2: `req_valid` is not raised until at least `SETTLE_TICKS` clocks after `slv_rst_n` rises. The default of 55000 clocks is 1.1 ms at 50 MHz.
- R3: The first access after the settle wait is a read of offset `VER_ADDR` (default 0x0039). It uses control byte 0x00: block select in bits [7:3] is 0 (common block), bit 2 is the write flag, and bits [1:0] are 00 (length set by the chip-select window).
- R4: If the version byte is not 0x04, `err` rises with `err_code` = 2'b01 and no write request is issued.
- R5: The hardware address is written with control byte 0x04 as six single-byte writes to offsets 0x0009 up to 0x000E. `mac_in[47:40]` goes to 0x0009 first, and `mac_in[7:0]` goes to 0x000E last.
- R6: The six bytes are then read from 0x0009 to 0x000E with control byte 0x00. If any byte differs from the byte written, `err` rises with `err_code` = 2'b10.
- R7: When all six bytes match, `ready` rises with `err` = 0 and `err_code` = 2'b00, and stays high until the next `start`.
- R8: `err` and `err_code` stay fixed until the next `start`. While `ready` or `err` is high, no request is issued.
- R9: Once raised, `req_valid` stays high with its address, control and data unchanged until `req_ready` is seen. The next request is raised only after `resp_valid` has returned for the previous one.
- R10: A `start` pulse at any point abandons the current access and restarts the sequence from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the sequence starts when it is released |
| start | input | 1 | One-cycle pulse that restarts the bring-up |
| mac_in | input | 48 | Hardware address to program; bits [47:40] are sent first |
| slv_rst_n | output | 1 | Active-low reset to the controller |
| req_valid | output | 1 | A byte access is offered to the frame master |
| req_ready | input | 1 | The frame master accepts the access |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Register offset |
| req_ctrl | output | 8 | Control byte: {block[4:0], write, mode[1:0]} |
| req_wdata | output | 8 | Write data byte |
| resp_valid | input | 1 | The access has completed |
| resp_rdata | input | 8 | Read data, valid with `resp_valid` |
| ready | output | 1 | Bring-up succeeded |
| err | output | 1 | Bring-up failed |
| err_code | output | 2 | 01 = version mismatch, 10 = readback mismatch |

## Verification
The bound checker enforces the timing rules on every cycle. It checks the minimum reset-low length, the settle gap before the first request and the silence of the request port during reset. It also checks that requests are held stable until accepted, that writes stay inside the address window, and that `ready` and `err` hold with a consistent code. The bench's scenarios show the things that depend on content: which bytes reached which offsets and in what order, whether the version and readback decisions produce the right code, and whether a restart in mid-write recovers cleanly. For these it uses a slave model with a programmable version value and readback corruption.

// File: rtl/bup_pkg.sv
package bup_pkg;

  typedef enum logic [3:0] {
    ST_RESET_ASSERT,
    ST_SETTLE,
    ST_READ_VER,
    ST_CHECK_VER,
    ST_WRITE_MAC,
    ST_READ_MAC,
    ST_CHECK_MAC,
    ST_READY,
    ST_ERROR
  } bup_state_e;

  localparam logic [1:0] ERR_NONE = 2'b00;
  localparam logic [1:0] ERR_VER  = 2'b01;
  localparam logic [1:0] ERR_MAC  = 2'b10;

  // control byte: common block (0), write flag, variable-length mode (00)
  function automatic logic [7:0] ctrl_byte(input logic wr);
    return {5'b00000, wr, 2'b00};
  endfunction

endpackage

// File: rtl/bup_delay.sv
module bup_delay #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/bup_req.sv
module bup_req (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        issue,
  input  logic        wr,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_write,
  output logic [15:0] req_addr,
  output logic [7:0]  req_ctrl,
  output logic [7:0]  req_wdata,
  input  logic        resp_valid,
  input  logic [7:0]  resp_rdata,
  output logic        done,
  output logic [7:0]  rdata
);
  import bup_pkg::*;

  logic waiting;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      req_valid <= 1'b0;
      waiting   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (issue) begin
        req_valid <= 1'b1;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        waiting   <= 1'b1;
      end else if (waiting && resp_valid) begin
        waiting <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_write <= 1'b0;
      req_addr  <= '0;
      req_ctrl  <= '0;
      req_wdata <= '0;
      rdata     <= '0;
    end else begin
      if (issue) begin
        req_write <= wr;
        req_addr  <= addr;
        req_ctrl  <= ctrl_byte(wr);
        req_wdata <= wdata;
      end
      if (waiting && resp_valid) rdata <= resp_rdata;
    end
  end
endmodule

// File: rtl/bup_seq.sv
module bup_seq #(
  parameter int          RST_TICKS    = 25000,
  parameter int          SETTLE_TICKS = 55000,
  parameter logic [15:0] VER_ADDR     = 16'h0039,
  parameter logic [7:0]  VER_EXPECT   = 8'h04,
  parameter logic [15:0] MAC_BASE     = 16'h0009,
  parameter int          MAC_BYTES    = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [8*MAC_BYTES-1:0] mac_in,
  output logic                   slv_rst_n,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic                   req_write,
  output logic [15:0]            req_addr,
  output logic [7:0]             req_ctrl,
  output logic [7:0]             req_wdata,
  input  logic                   resp_valid,
  input  logic [7:0]             resp_rdata,
  output logic                   ready,
  output logic                   err,
  output logic [1:0]             err_code
);
  import bup_pkg::*;

  localparam int MAXT = (RST_TICKS > SETTLE_TICKS) ? RST_TICKS : SETTLE_TICKS;
  localparam int CW   = $clog2(MAXT) + 1;
  localparam int IW   = (MAC_BYTES > 1) ? $clog2(MAC_BYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(MAC_BYTES - 1);

  bup_state_e    state;
  logic          dly_load, dly_zero;
  logic [CW-1:0] dly_val;
  logic          issued, mism, issue, done;
  logic [IW-1:0] idx;
  logic [7:0]    ver_q, rdata;
  logic [7:0]    mac_b [MAC_BYTES];

  // byte 0 is the most significant byte and goes to the lowest offset
  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_split
    assign mac_b[g] = mac_in[8*(MAC_BYTES-1-g) +: 8];
  end

  bup_delay #(.CW(CW)) u_dly (
    .clk(clk), .rst(rst), .load(dly_load), .load_val(dly_val), .zero(dly_zero)
  );

  assign issue = !issued &&
                 (state == ST_READ_VER || state == ST_WRITE_MAC || state == ST_READ_MAC);

  bup_req u_req (
    .clk(clk), .rst(rst), .flush(start), .issue(issue),
    .wr(state == ST_WRITE_MAC),
    .addr((state == ST_READ_VER) ? VER_ADDR : MAC_BASE + 16'(idx)),
    .wdata(mac_b[idx]),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_ctrl(req_ctrl), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .done(done), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) slv_rst_n <= 1'b0;
    else     slv_rst_n <= (state != ST_RESET_ASSERT) && !start;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      state    <= ST_RESET_ASSERT;
      dly_load <= 1'b1;
      dly_val  <= CW'(RST_TICKS - 1);
      issued   <= 1'b0;
      idx      <= '0;
      mism     <= 1'b0;
      ver_q    <= '0;
      ready    <= 1'b0;
      err      <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      dly_load <= 1'b0;
      if (issue) issued <= 1'b1;
      case (state)
        ST_RESET_ASSERT: if (!dly_load && dly_zero) begin
          state    <= ST_SETTLE;
          dly_load <= 1'b1;
          dly_val  <= CW'(SETTLE_TICKS - 1);
        end
        ST_SETTLE: if (!dly_load && dly_zero) state <= ST_READ_VER;
        ST_READ_VER: if (done) begin
          ver_q  <= rdata;
          issued <= 1'b0;
          state  <= ST_CHECK_VER;
        end
        ST_CHECK_VER: if (ver_q == VER_EXPECT) begin
          idx   <= '0;
          state <= ST_WRITE_MAC;
        end else begin
          err      <= 1'b1;
          err_code <= ERR_VER;
          state    <= ST_ERROR;
        end
        ST_WRITE_MAC: if (done) begin
          issued <= 1'b0;
          if (idx == LAST) begin
            idx   <= '0;
            state <= ST_READ_MAC;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_READ_MAC: if (done) begin
          issued <= 1'b0;
          if (rdata != mac_b[idx]) mism <= 1'b1;
          if (idx == LAST) state <= ST_CHECK_MAC;
          else             idx   <= idx + 1'b1;
        end
        ST_CHECK_MAC: if (mism) begin
          err      <= 1'b1;
          err_code <= ERR_MAC;
          state    <= ST_ERROR;
        end else begin
          ready <= 1'b1;
          state <= ST_READY;
        end
        ST_READY, ST_ERROR: state <= state;
        default: state <= ST_ERROR;
      endcase
    end
  end
endmodule

// File: rtl/bup_chk.sv
module bup_chk #(
  parameter int          RST_TICKS    = 25000,
  parameter int          SETTLE_TICKS = 55000,
  parameter logic [15:0] MAC_BASE     = 16'h0009,
  parameter int          MAC_BYTES    = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        slv_rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [15:0] req_addr,
  input logic [7:0]  req_ctrl,
  input logic        ready,
  input logic        err,
  input logic [1:0]  err_code
);
  logic [31:0] low_cnt, high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else if (!slv_rst_n) begin
      low_cnt  <= low_cnt + 1;
      high_cnt <= '0;
    end else begin
      low_cnt  <= '0;
      if (high_cnt != 32'hFFFF_FFFF) high_cnt <= high_cnt + 1;
    end
  end

  assert_rst_low_min_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(slv_rst_n) |-> low_cnt >= RST_TICKS);

  assert_quiet_in_reset_R1: assert property (@(posedge clk) disable iff (rst)
    !slv_rst_n |-> !req_valid);

  assert_settle_gap_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> high_cnt >= SETTLE_TICKS);

  assert_write_window_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |->
      (req_addr >= MAC_BASE && req_addr < MAC_BASE + 16'(MAC_BYTES) && req_ctrl == 8'h04));

  assert_ready_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ready && !start) |=> ready);

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> (err && $stable(err_code)));

  assert_err_code_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code != 2'b00 && !ready));

  assert_idle_when_done_R8: assert property (@(posedge clk) disable iff (rst)
    (ready || err) |-> !req_valid);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !start) |=>
      (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_ctrl)));
endmodule

bind bup_seq bup_chk #(
  .RST_TICKS(RST_TICKS), .SETTLE_TICKS(SETTLE_TICKS),
  .MAC_BASE(MAC_BASE), .MAC_BYTES(MAC_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .slv_rst_n(slv_rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_ctrl(req_ctrl),
  .ready(ready), .err(err), .err_code(err_code)
);

// File: tb/tb_bup_seq.sv
module tb_bup_seq;
  localparam int RST_T = 8;
  localparam int SET_T = 12;
  localparam logic [15:0] VER_A = 16'h0039;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [47:0] mac_in = '0;
  logic        slv_rst_n, req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_ctrl, req_wdata, resp_rdata;
  logic        resp_valid, ready, err;
  logic [1:0]  err_code;

  always #10 clk = ~clk;

  bup_seq #(.RST_TICKS(RST_T), .SETTLE_TICKS(SET_T), .VER_ADDR(VER_A)) dut (
    .clk(clk), .rst(rst), .start(start), .mac_in(mac_in), .slv_rst_n(slv_rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_ctrl(req_ctrl), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .ready(ready), .err(err), .err_code(err_code)
  );

  // slave model configuration, driven from the initial block
  logic [7:0]  cfg_ver  = 8'h04;
  logic [47:0] cfg_flip = '0;
  logic        clr = 1'b0;

  // slave model state
  logic [7:0]  mem [6];
  logic [7:0]  rd_hold;
  logic [1:0]  lat;
  logic [3:0]  pat;
  int          wr_count, ctrl_bad, first_wr_addr, first_wr_data, first_rd_addr;

  always @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0; resp_rdata <= '0; req_ready <= 1'b0;
      lat <= '0; pat <= 4'b1011; rd_hold <= '0;
      for (int i = 0; i < 6; i++) mem[i] <= '0;
    end else begin
      pat <= {pat[2:0], pat[3] ^ pat[2]};
      resp_valid <= 1'b0;
      if (lat != 0) begin
        lat <= lat - 1'b1;
        if (lat == 2'd1) begin resp_valid <= 1'b1; resp_rdata <= rd_hold; end
      end else if (req_valid && req_ready) begin
        req_ready <= 1'b0;
        lat <= 2'd2;
        if (req_write) begin
          if (req_addr >= 16'h0009 && req_addr <= 16'h000E) mem[req_addr - 16'h0009] <= req_wdata;
          rd_hold <= 8'h00;
        end else if (req_addr == VER_A) begin
          rd_hold <= cfg_ver;
        end else if (req_addr >= 16'h0009 && req_addr <= 16'h000E) begin
          rd_hold <= mem[req_addr - 16'h0009] ^ cfg_flip[8*(5-(req_addr-16'h0009)) +: 8];
        end else begin
          rd_hold <= 8'hEE;
        end
      end else begin
        req_ready <= pat[0];
      end
    end
  end

  // access log (own variables only)
  always @(posedge clk) begin
    if (rst || clr) begin
      wr_count <= 0; ctrl_bad <= 0; first_wr_addr <= -1; first_wr_data <= -1; first_rd_addr <= -1;
    end else if (req_valid && req_ready && lat == 0) begin
      if (first_rd_addr < 0 && !req_write) first_rd_addr <= int'(req_addr);
      if (req_write) begin
        wr_count <= wr_count + 1;
        if (first_wr_addr < 0) begin first_wr_addr <= int'(req_addr); first_wr_data <= int'(req_wdata); end
      end
      if (req_ctrl != (req_write ? 8'h04 : 8'h00)) ctrl_bad <= ctrl_bad + 1;
    end
  end

  // reset-low length and settle gap, measured at the falling edge
  int  low_run = 0, low_last = 0, gap = 0, gap_last = 0;
  bit  seen = 0;
  always @(negedge clk) begin
    if (!slv_rst_n) begin
      low_run = low_run + 1; seen = 0; gap = 0;
    end else begin
      if (low_run != 0) begin low_last = low_run; low_run = 0; end
      if (!seen) begin
        if (req_valid) begin seen = 1; gap_last = gap; end
        else gap = gap + 1;
      end
    end
  end

  int total = 0, bad = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  typedef struct packed {
    logic [47:0] mac;
    logic [7:0]  ver;
    logic [47:0] flip;
    logic [1:0]  code;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{mac: 48'h0008DC010203, ver: 8'h04, flip: 48'h0,            code: 2'b00},
    '{mac: 48'hA1B2C3D4E5F6, ver: 8'h05, flip: 48'h0,            code: 2'b01},
    '{mac: 48'h112233445566, ver: 8'h00, flip: 48'h0,            code: 2'b01},
    '{mac: 48'hFFFFFFFFFFFF, ver: 8'h04, flip: 48'h000000000001, code: 2'b10},
    '{mac: 48'h0123456789AB, ver: 8'h04, flip: 48'h800000000000, code: 2'b10},
    '{mac: 48'h000000000000, ver: 8'h04, flip: 48'h0,            code: 2'b00}
  };

  task automatic wait_end(output bit ok);
    int n = 0;
    while (!(ready || err) && n < 3000) begin @(negedge clk); n++; end
    ok = (ready || err);
  endtask

  task automatic pulse_start();
    @(negedge clk); clr = 1'b1; start = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b0;
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    check(slv_rst_n == 1'b0, "R1 reset slv_rst_n", slv_rst_n, 0);
    check(req_valid == 1'b0, "R1 reset req_valid", req_valid, 0);
    check(ready == 1'b0 && err == 1'b0, "R7 reset ready/err", {ready, err}, 0);
    rst = 1'b0;
    wait_end(ok);
    check(ok && ready, "R7 power-up run ready", ready, 1);

    foreach (VEC[v]) begin
      mac_in = VEC[v].mac; cfg_ver = VEC[v].ver; cfg_flip = VEC[v].flip;
      pulse_start();
      wait_end(ok);
      check(ok, "R8 run completes", ok, 1);
      check(low_last >= RST_T, "R1 reset low length", low_last, RST_T);
      check(gap_last >= SET_T, "R2 settle gap", gap_last, SET_T);
      check(first_rd_addr == int'(VER_A), "R3 first read is version", first_rd_addr, VER_A);
      check(ctrl_bad == 0, "R3 control bytes", ctrl_bad, 0);
      check(err_code == VEC[v].code, "R4/R6 err_code", err_code, VEC[v].code);
      check(err == (VEC[v].code != 2'b00), "R8 err flag", err, VEC[v].code != 0);
      check(ready == (VEC[v].code == 2'b00), "R7 ready flag", ready, VEC[v].code == 0);
      if (VEC[v].code == 2'b01) begin
        check(wr_count == 0, "R4 no writes after bad version", wr_count, 0);
      end else begin
        check(wr_count == 6, "R5 six writes", wr_count, 6);
        check(first_wr_addr == 9, "R5 first write offset", first_wr_addr, 9);
        check(first_wr_data == int'(VEC[v].mac[47:40]), "R5 first write byte", first_wr_data, VEC[v].mac[47:40]);
        check({mem[0], mem[1], mem[2], mem[3], mem[4], mem[5]} == VEC[v].mac,
              "R5 stored address", {mem[0], mem[1], mem[2], mem[3], mem[4], mem[5]}, VEC[v].mac);
      end
      repeat (40) @(negedge clk);
      check(err_code == VEC[v].code, "R8 code holds", err_code, VEC[v].code);
      check(ready == (VEC[v].code == 2'b00), "R7 ready holds", ready, VEC[v].code == 0);
      check(req_valid == 1'b0, "R8 no requests when finished", req_valid, 0);
    end

    // restart in the middle of the address writes
    mac_in = 48'h5A5A12345678; cfg_ver = 8'h04; cfg_flip = '0;
    pulse_start();
    begin
      int n = 0;
      while (!(req_valid && req_write && req_addr == 16'h000B) && n < 3000) begin @(negedge clk); n++; end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(slv_rst_n == 1'b0, "R10 restart drops reset", slv_rst_n, 0);
    check(req_valid == 1'b0, "R10 restart clears request", req_valid, 0);
    mac_in = 48'hC0FFEE001122;
    wait_end(ok);
    check(ok && ready && !err, "R10 restart completes", {ready, err}, 2'b10);
    check({mem[0], mem[1], mem[2], mem[3], mem[4], mem[5]} == 48'hC0FFEE001122,
          "R10 address after restart", {mem[0], mem[1], mem[2], mem[3], mem[4], mem[5]}, 48'hC0FFEE001122);

    // error persists until start, then clears
    cfg_ver = 8'h07;
    pulse_start();
    wait_end(ok);
    check(err && err_code == 2'b01, "R8 error entered", err_code, 1);
    repeat (100) @(negedge clk);
    check(err && err_code == 2'b01, "R8 error sticky", err_code, 1);
    cfg_ver = 8'h04;
    pulse_start();
    check(err == 1'b0 && err_code == 2'b00, "R8 start clears error", {err, err_code}, 0);
    wait_end(ok);
    check(ready, "R9 handshakes complete under stalls", ready, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule